// File: doc/BRIEF.md
# Region-Based Memory Access Checker

This block sits beside a bus and judges every access against a bank of programmable protection regions. Each region carries a base address, a power-of-two size, an enable, an eight-bit mask that carves out any of its eight equal slices, and a three-bit permission code. The permission code gives one rule for privileged masters and a separate rule for unprivileged masters. An access presents an address, a read/write flag and a privilege flag. One cycle later the block answers with either a grant or a one-cycle fault pulse.

A configuration port programs one region per write. The same port also sets the global enable and clears the fault log. While the global enable is low, every access is granted, as though the checker were absent. When the first fault occurs, the fault log captures its address, direction and privilege. The log holds those values until software clears it.

Two small state machines carry the behaviour. The fault log has two named states. In `FL_EMPTY` the log waits for a fault. The transition *capture* moves it to `FL_HELD` on the first fault, and the transition *clear* returns it to `FL_EMPTY` on a clear write. The response path has two states. In `RS_IDLE` no response is shown. The transition *accept* moves it to `RS_ANSWER` for one cycle after each access. It stays in `RS_ANSWER` while accesses arrive back to back, and takes the transition *drain* back to `RS_IDLE` when they stop.

Top module: `region_access_checker`

## Requirements
- R1: After reset, no response is shown, the fault log is empty, the global enable is off and all regions are disabled.
- R2: While the global enable is off, every access is granted and no fault is logged.
- R3: The region size is written as log2(bytes). Values below 5 are stored as 5 and values above 32 are stored as 32. Address bits below the size are ignored in both the base and the access address, so size 32 covers the whole space.
- R4: Bit k of the slice mask removes slice k from the region. Slice k is selected by address bits [size-1:size-3]. An address in a removed slice is treated as if that region did not match it.
- R5: When several enabled regions match an address, the permission code of the highest-numbered region applies.
- R6: An access that matches no enabled region is granted when privileged and faulted when unprivileged.
- R7: The permission code decodes as follows. 0 allows nothing. 1 gives privileged read-write only. 2 gives privileged read-write and user read. 3 allows everything. 5 gives privileged read only. 6 gives read only to both. Codes 4 and 7 allow nothing.
- R8: A response appears exactly one cycle after each access, with exactly one of grant or fault high. Fault is a single-cycle pulse per denied access. No response appears in a cycle that follows no access.
- R9: On the first fault after reset or after a clear, the log captures the address, the write flag and the privilege flag. Later faults leave the log unchanged.
- R10: A clear write (operation code 2) empties the log from the next cycle. Operation code 1 writes the global enable, operation code 0 writes the region named by the index, and operation code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 region, 1 global enable, 2 clear log, 3 none |
| cfg_idx | input | 4 | Region index for operation code 0 |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 6 | Region size as log2(bytes) |
| cfg_sub_off | input | 8 | Slice removal mask |
| cfg_perm | input | 3 | Permission code |
| cfg_en | input | 1 | Region enable, or global enable for operation code 1 |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged master |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access denied (pulse) |
| flt_valid | output | 1 | Fault log holds an entry |
| flt_addr | output | 32 | Logged fault address |
| flt_write | output | 1 | Logged write flag |
| flt_priv | output | 1 | Logged privilege flag |

## Verification
A wrong stored size, base or slice mask sends an access into the wrong region. This shows up at the response of the very next access to that address, as a grant where a fault was expected or the reverse. A wrong priority choice or permission decode shows up the same way, one cycle after the access. A fault log that recaptures or fails to capture is seen on the log outputs in the same cycle as the fault pulse, and the error persists until the next clear. The checks therefore compare every response, and the log contents after every access, against a model of the region table.

// File: rtl/rac_pkg.sv
package rac_pkg;
    localparam int ADDR_W = 32;
    localparam int SZ_W   = 6;
    localparam int PERM_W = 3;
    localparam int SUB_N  = 8;

    typedef enum logic [1:0] {
        OP_REGION = 2'd0,
        OP_GLOBAL = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_NONE   = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [SZ_W-1:0]   size;
        logic [SUB_N-1:0]  sub_off;
        logic [PERM_W-1:0] perm;
    } region_t;

    function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                         input logic priv, input logic wr);
        logic ok;
        unique case (perm)
            3'd1:    ok = priv;
            3'd2:    ok = priv | ~wr;
            3'd3:    ok = 1'b1;
            3'd5:    ok = priv & ~wr;
            3'd6:    ok = ~wr;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] s);
        logic [SZ_W-1:0] r;
        if (s < 6'd5)       r = 6'd5;
        else if (s > 6'd32) r = 6'd32;
        else                r = s;
        return r;
    endfunction
endpackage

// File: rtl/rac_region.sv
module rac_region
    import rac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  region_t           wdata,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [PERM_W-1:0] perm
);
    region_t          cfg_q;
    logic [63:0]      wide_mask;
    logic [ADDR_W-1:0] hi_mask;
    logic [ADDR_W-1:0] shifted;
    logic [2:0]       slice;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cfg_q.size <= 6'd5;
        end else if (wr) begin
            cfg_q <= wdata;
            cfg_q.size <= clamp_size(wdata.size);
        end
    end

    always_comb begin
        wide_mask = {64{1'b1}} << cfg_q.size;
        hi_mask   = wide_mask[ADDR_W-1:0];
        shifted   = addr >> (cfg_q.size - 6'd3);
        slice     = shifted[2:0];
        hit       = cfg_q.en && ((addr & hi_mask) == (cfg_q.base & hi_mask))
                    && !cfg_q.sub_off[slice];
        perm      = cfg_q.perm;
    end

    // R3: stored size always lies in the legal range
    p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.size >= 6'd5) && (cfg_q.size <= 6'd32));
endmodule

// File: rtl/rac_prio.sv
module rac_prio
    import rac_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]             hits,
    input  logic [N-1:0][PERM_W-1:0] perms,
    output logic                     any_hit,
    output logic [PERM_W-1:0]        sel_perm
);
    always_comb begin
        any_hit  = 1'b0;
        sel_perm = '0;
        for (int i = 0; i < N; i++) begin
            if (hits[i]) begin
                any_hit  = 1'b1;
                sel_perm = perms[i];
            end
        end
    end
endmodule

// File: rtl/rac_fault_log.sv
module rac_fault_log
    import rac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              priv,
    output logic              valid,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_q,
    output logic              priv_q
);
    typedef enum logic {FL_EMPTY, FL_HELD} fl_state_e;
    fl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_EMPTY: if (cap && !clr) state_d = FL_HELD;
            FL_HELD:  if (clr)         state_d = FL_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wr_q   <= 1'b0;
            priv_q <= 1'b0;
        end else if (state_q == FL_EMPTY && state_d == FL_HELD) begin
            addr_q <= addr;
            wr_q   <= wr;
            priv_q <= priv;
        end
    end

    assign valid = (state_q == FL_HELD);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clr) |=> (valid && $stable(addr_q) && $stable(wr_q) && $stable(priv_q)));
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && cap && !clr) |=> (valid && addr_q == $past(addr)));
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid);
endmodule

// File: rtl/region_access_checker.sv
module region_access_checker
    import rac_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_op,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic [SUB_N-1:0]  cfg_sub_off,
    input  logic [PERM_W-1:0] cfg_perm,
    input  logic              cfg_en,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_priv,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic              flt_write,
    output logic              flt_priv
);
    typedef enum logic {RS_IDLE, RS_ANSWER} rs_state_e;

    rs_state_e  rs_q, rs_d;
    logic       glob_en;
    logic       ok_d, ok_q;
    logic       any_hit;
    logic [PERM_W-1:0] sel_perm;
    logic [NUM_REGIONS-1:0]             hits;
    logic [NUM_REGIONS-1:0][PERM_W-1:0] perms;
    region_t    wdata;

    assign wdata = '{en: cfg_en, base: cfg_base, size: cfg_size,
                     sub_off: cfg_sub_off, perm: cfg_perm};

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        rac_region u_region (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (cfg_we && cfg_op == OP_REGION && cfg_idx == IDX_W'(i)),
            .wdata (wdata),
            .addr  (acc_addr),
            .hit   (hits[i]),
            .perm  (perms[i])
        );
    end

    rac_prio #(.N(NUM_REGIONS)) u_prio (
        .hits     (hits),
        .perms    (perms),
        .any_hit  (any_hit),
        .sel_perm (sel_perm)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            glob_en <= 1'b0;
        else if (cfg_we && cfg_op == OP_GLOBAL) glob_en <= cfg_en;
    end

    always_comb begin
        if (!glob_en)     ok_d = 1'b1;
        else if (any_hit) ok_d = perm_allows(sel_perm, acc_priv, acc_write);
        else              ok_d = acc_priv;
    end

    always_comb begin
        rs_d = rs_q;
        unique case (rs_q)
            RS_IDLE:   if (acc_valid)  rs_d = RS_ANSWER;
            RS_ANSWER: if (!acc_valid) rs_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= RS_IDLE;
            ok_q <= 1'b0;
        end else begin
            rs_q <= rs_d;
            ok_q <= ok_d;
        end
    end

    always_comb begin
        rsp_valid = (rs_q == RS_ANSWER);
        rsp_grant = rsp_valid && ok_q;
        rsp_fault = rsp_valid && !ok_q;
    end

    rac_fault_log u_log (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_we && cfg_op == OP_CLEAR),
        .cap    (acc_valid && !ok_d),
        .addr   (acc_addr),
        .wr     (acc_write),
        .priv   (acc_priv),
        .valid  (flt_valid),
        .addr_q (flt_addr),
        .wr_q   (flt_write),
        .priv_q (flt_priv)
    );

    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_grant, rsp_fault}));
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !glob_en) |=> rsp_grant);
    p_background_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && glob_en && !any_hit) |=> (rsp_grant == $past(acc_priv)));
endmodule

// File: tb/sim_region_access_checker.sv
module sim_region_access_checker;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0; logic [1:0] cfg_op = 3; logic [3:0] cfg_idx = 0;
    logic [31:0] cfg_base = 0; logic [5:0] cfg_size = 0; logic [7:0] cfg_sub_off = 0;
    logic [2:0] cfg_perm = 0; logic cfg_en = 0;
    logic acc_valid = 0; logic [31:0] acc_addr = 0; logic acc_write = 0, acc_priv = 0;
    logic rsp_valid, rsp_grant, rsp_fault, flt_valid, flt_write, flt_priv;
    logic [31:0] flt_addr;

    int checks = 0, errors = 0;
    logic        m_en[NR]; logic [31:0] m_base[NR]; int m_sz[NR];
    logic [7:0]  m_sub[NR]; logic [2:0] m_perm[NR]; logic m_glob;
    logic e_fv, e_fw, e_fp; logic [31:0] e_fa;

    region_access_checker u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit perm_ok(input logic [2:0] p, input logic pr, input logic w);
        case (p)
            3'd1: return pr;
            3'd2: return pr || !w;
            3'd3: return 1;
            3'd5: return pr && !w;
            3'd6: return !w;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_ok(input logic [31:0] a, input logic w, input logic pr);
        bit hit = 0; logic [2:0] p = 0;
        if (!m_glob) return 1;
        for (int r = 0; r < NR; r++) begin
            logic [31:0] mask; int s = m_sz[r]; int sub;
            mask = (s == 32) ? 32'd0 : ~((32'd1 << s) - 32'd1);
            sub = int'((a >> (s - 3)) & 32'd7);
            if (m_en[r] && ((a & mask) == (m_base[r] & mask)) && !m_sub[r][sub]) begin
                hit = 1; p = m_perm[r];
            end
        end
        return hit ? perm_ok(p, pr, w) : pr;
    endfunction

    task automatic cfg(input logic [1:0] op, input int idx, input logic [31:0] b, input int s,
                       input logic [7:0] so, input logic [2:0] pm, input logic en);
        @(negedge clk);
        cfg_we = 1; cfg_op = op; cfg_idx = 4'(idx); cfg_base = b; cfg_size = 6'(s);
        cfg_sub_off = so; cfg_perm = pm; cfg_en = en;
        @(negedge clk);
        cfg_we = 0; cfg_op = 3;
        if (op == 0) begin
            m_en[idx] = en; m_base[idx] = b; m_sz[idx] = (s < 5) ? 5 : (s > 32 ? 32 : s);
            m_sub[idx] = so; m_perm[idx] = pm;
        end else if (op == 1) m_glob = en;
        else if (op == 2) e_fv = 0;
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic w, input logic pr);
        bit ok;
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_write = w; acc_priv = pr;
        ok = exp_ok(a, w, pr);
        @(negedge clk);
        acc_valid = 0;
        if (!ok && !e_fv) begin e_fv = 1; e_fa = a; e_fw = w; e_fp = pr; end
        chk("R8", "rsp_valid", 32'(rsp_valid), 1);
        chk(req, "rsp_grant", 32'(rsp_grant), 32'(ok));
        chk(req, "rsp_fault", 32'(rsp_fault), 32'(!ok));
        chk("R9", "flt_valid", 32'(flt_valid), 32'(e_fv));
        if (e_fv) begin
            chk("R9", "flt_addr", flt_addr, e_fa);
            chk("R9", "flt_flags", {30'd0, flt_write, flt_priv}, {30'd0, e_fw, e_fp});
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_glob = 0; e_fv = 0; e_fa = 0; e_fw = 0; e_fp = 0;
        for (int r = 0; r < NR; r++) begin
            m_en[r] = 0; m_base[r] = 0; m_sz[r] = 5; m_sub[r] = 0; m_perm[r] = 0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "reset rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "reset flt_valid", 32'(flt_valid), 0);
        access("R1", 32'h1000, 1, 0);
        access("R2", 32'hdead_beef, 1, 0);
        @(negedge clk);
        chk("R8", "no access no response", 32'(rsp_valid), 0);
        cfg(1, 0, 0, 0, 0, 0, 1);
        access("R6", 32'h2000, 0, 1);
        access("R6", 32'h2004, 1, 0);
        access("R9", 32'h3000, 0, 0);
        cfg(2, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R10", "cleared", 32'(flt_valid), 0);
        cfg(3, 0, 0, 0, 0, 0, 0);
        access("R10", 32'h2000, 0, 1);
        cfg(0, 0, 32'h0, 40, 8'h00, 3'd3, 1);
        access("R3", 32'hffff_fff0, 1, 0);
        cfg(0, 1, 32'h0001_0123, 8, 8'h00, 3'd6, 1);
        access("R3", 32'h0001_0000, 1, 1);
        access("R3", 32'h0001_00ff, 0, 0);
        cfg(0, 2, 32'h0004_0000, 10, 8'b0000_0100, 3'd0, 1);
        access("R4", 32'h0004_0100, 0, 1);
        access("R4", 32'h0004_0200, 0, 1);
        cfg(0, 3, 32'h0004_0000, 12, 8'h00, 3'd2, 1);
        access("R5", 32'h0004_0100, 0, 0);
        cfg(0, 3, 32'h0004_0000, 12, 8'h00, 3'd2, 0);
        access("R5", 32'h0004_0100, 0, 0);
        for (int p = 0; p < 8; p++) begin
            cfg(0, 15, 32'h8000_0000, 20, 8'h00, 3'(p), 1);
            for (int k = 0; k < 4; k++) access("R7", 32'h8000_0040, k[0], k[1]);
        end
        cfg(1, 0, 0, 0, 0, 0, 0);
        access("R2", 32'h8000_0040, 1, 0);
        cfg(1, 0, 0, 0, 0, 0, 1);
        for (int it = 0; it < 600; it++) begin
            int sel = int'($urandom_range(0, 9));
            if (sel == 0) begin
                int idx = int'($urandom_range(0, NR-1));
                cfg(0, idx, $urandom & 32'h00ff_ffff, int'($urandom_range(3, 33)),
                    8'($urandom), 3'($urandom), 1'($urandom));
            end else if (sel == 1) cfg(2, 0, 0, 0, 0, 0, 0);
            else begin
                logic [31:0] a = $urandom;
                int r = int'($urandom_range(0, NR-1));
                if ($urandom_range(0, 3) != 0)
                    a = m_base[r] + ($urandom & ((m_sz[r] >= 32) ? 32'hffff_ffff : ((32'd1 << m_sz[r]) - 1)));
                access("R7", a, 1'($urandom), 1'($urandom));
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule